// File: doc/BRIEF.md
# ULPI PHY-side command and turnaround controller

This block sits on the PHY end of an 8-bit single-data-rate ULPI bus running from the 60 MHz bus clock. It owns the DIR and NXT lines and samples STP. When DIR is high it drives the shared data byte, and when DIR is low it releases the byte. It decodes the command bytes the link sends. Register writes and reads come in an immediate form with a 6-bit address and an extended form with a full 8-bit address. Transmit commands hand their PID and the payload bytes that follow to a serializer outside this block.

Register accesses go to a small internal register bank. Whenever the bus is idle and the line state, VBUS state or receive-event field differs from what was last reported, the block turns the bus around and sends a one-byte receive status. After reset it holds DIR high for a configurable number of clocks and then releases the bus. Each time DIR changes level, one turnaround cycle passes before the new owner of the bus drives it.

Top module: `ulpi_phy_port`

## Requirements
- R1: While reset is low, and for PWRUP_CYCLES clocks after it is released, DIR is high, NXT is low and the data byte is not driven. DIR falls in the following cycle.
- R2: Link byte bits [7:6] select the operation: 10 register write, 11 register read, 01 transmit. A byte with 00 in these bits raises neither NXT nor DIR.
- R3: NXT rises in the cycle after a command byte appears. It stays high through the cycle in which the last byte of the command (data byte, or extended address byte for a read) is taken, and is low in the cycle after a write's data byte.
- R4: A command whose bits [5:0] equal 2Fh is extended, and the link's next byte is the 8-bit address. Immediate commands use bits [5:0] as the address. Addresses at or above REG_COUNT read as 00h, and writes to them are discarded.
- R5: A write reaches the register bank only if STP is high in the cycle after the data byte. Without STP there, the register keeps its value.
- R6: After a read command (and its address byte) is taken, DIR rises for one undriven turnaround cycle. The next cycle drives the register value with NXT low, and DIR then falls.
- R7: In the cycle after DIR falls, the PHY neither drives the bus nor decodes the link's byte. A command placed only in that cycle is lost.
- R8: When idle with no command present and the status {rx_event, vbus_state, line_state} differs from the last reported value (00h after reset), the PHY raises DIR for one turnaround cycle. It then drives {2'b00, rx_event, vbus_state, line_state} for one cycle with NXT low, and DIR falls. An unchanged status sends nothing.
- R9: A command seen in the same idle cycle as a status change is served first. The status change is reported immediately after the command finishes.
- R10: A transmit command gives a one-cycle tx_start with tx_pid equal to command bits [3:0]. NXT stays high, and each byte the link presents before STP gives a one-cycle tx_valid with that byte. The STP cycle ends the transfer and its byte is discarded.
- R11: STP seen before a write's data byte is taken aborts the command, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_data | input | 8 | Byte driven by the link while DIR is low |
| phy_data | output | 8 | Byte driven by the PHY, 00h when not driving |
| phy_data_oe | output | 1 | PHY drives the data byte |
| dir | output | 1 | Bus direction, high when the PHY owns the bus |
| nxt | output | 1 | PHY accepts the current link byte |
| stp | input | 1 | Link ends or aborts the current command |
| line_state | input | 2 | Current line state for status reports |
| vbus_state | input | 2 | Current VBUS state code |
| rx_event | input | 2 | Current receive-event code |
| tx_start | output | 1 | One-cycle pulse when a transmit command is taken |
| tx_pid | output | 4 | PID of the last transmit command |
| tx_valid | output | 1 | One-cycle pulse per accepted payload byte |
| tx_byte | output | 8 | Accepted payload byte |

## Verification
The hardest case to reach is a status change that arrives while a register command is in flight. The report must be held back and sent only after the command ends, and it must not be lost or merged. The stimulus changes the status inputs in the same cycle that a write command is placed on the bus, then expects the status turnaround right after the STP cycle. A second hard case is a command that appears only during the turnaround cycle after DIR falls. The read sequence places a one-cycle command exactly there and confirms that NXT never answers it. Random rounds mix immediate and extended accesses, aborted and unterminated writes, repeated and changed status values and transmit bursts against a register model kept in the bench.

// File: rtl/ulpi_phy_pkg.sv
// Shared types for the ULPI PHY-side controller.
// Assumes an 8-bit single-data-rate bus; the status byte packs three 2-bit fields.
package ulpi_phy_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_FALL,
        ST_WCMD,
        ST_WADDR,
        ST_WDATA,
        ST_WEND,
        ST_RCMD,
        ST_RADDR,
        ST_RTURN,
        ST_RDATA,
        ST_XTURN,
        ST_XDATA,
        ST_TCMD,
        ST_TDATA
    } phy_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_TX    = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } link_op_e;

    localparam logic [5:0] EXT_ADDR_CODE = 6'h2F;

    typedef struct packed {
        logic [1:0] ev;
        logic [1:0] vbus;
        logic [1:0] line;
    } bus_status_t;

    function automatic logic [7:0] pack_status(input bus_status_t s);
        return {2'b00, s.ev, s.vbus, s.line};
    endfunction

endpackage

// File: rtl/ulpi_status_track.sv
// Keeps the last reported bus status and flags a difference.
// Assumes take pulses only in the idle cycle that launches a report.
module ulpi_status_track
    import ulpi_phy_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bus_status_t cur,
    input  logic        take,
    output logic        changed,
    output logic [7:0]  snap_byte
);

    bus_status_t last_q;
    logic [7:0]  snap_q;

    // Record the reported status and freeze the byte to send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            snap_q <= '0;
        end else if (take) begin
            last_q <= cur;
            snap_q <= pack_status(cur);
        end
    end

    // Difference between the live status and the last one reported.
    always_comb begin
        changed = (cur != last_q);
    end

    assign snap_byte = snap_q;

endmodule

// File: rtl/ulpi_reg_bank.sv
// Byte-wide register bank behind the command controller.
// Addresses at or above REG_COUNT read zero and ignore writes.
module ulpi_reg_bank #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int REG_COUNT = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0]        regs [REG_COUNT];
    logic [REG_COUNT-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < REG_COUNT; g++) begin : g_decode
            assign hit[g] = (addr == AW'(g));
        end
    endgenerate

    // Store write data into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                if (hit[i]) regs[i] <= wr_data;
            end
        end
    end

    // Read mux, zero when no register matches.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (hit[i]) rd_data = regs[i];
        end
    end

endmodule

// File: rtl/ulpi_cmd_fsm.sv
// Command decoder and bus-direction sequencer for the PHY side of ULPI.
// Samples the link byte and STP at each rising edge; DIR, NXT and the
// output enable decode the registered state, so they never glitch.
// Assumes the link holds each byte until it sees NXT high at an edge.
module ulpi_cmd_fsm
    import ulpi_phy_pkg::*;
#(
    parameter int PWRUP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] link_data,
    input  logic       stp,
    input  logic       stat_changed,
    input  logic [7:0] stat_byte,
    input  logic [7:0] reg_rdata,
    output logic       stat_take,
    output logic       dir,
    output logic       nxt,
    output logic       data_oe,
    output logic [7:0] data_out,
    output logic       reg_we,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       tx_start,
    output logic [3:0] tx_pid,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);

    localparam int               PW_W    = $clog2(PWRUP_CYCLES) + 1;
    localparam logic [PW_W-1:0]  PW_LAST = PW_W'(PWRUP_CYCLES - 1);

    phy_state_e      st;
    logic [PW_W-1:0] pw_cnt;
    logic            ext_q;
    logic [7:0]      addr_q;
    logic [7:0]      wdat_q;
    logic [7:0]      out_q;
    logic            we_q;
    logic            tx_start_q;
    logic [3:0]      tx_pid_q;
    logic            tx_valid_q;
    logic [7:0]      tx_byte_q;
    link_op_e        op;

    assign op = link_op_e'(link_data[7:6]);

    // Launch a status report only from idle with no command on the bus.
    always_comb begin
        stat_take = (st == ST_IDLE) && (op == OP_NONE) && stat_changed;
    end

    // Bus-facing controls decoded from the registered state.
    always_comb begin
        dir     = (st == ST_PWRUP) || (st == ST_RTURN) || (st == ST_RDATA) ||
                  (st == ST_XTURN) || (st == ST_XDATA);
        nxt     = (st == ST_WCMD)  || (st == ST_WADDR) || (st == ST_WDATA) ||
                  (st == ST_RCMD)  || (st == ST_RADDR) ||
                  (st == ST_TCMD)  || (st == ST_TDATA);
        data_oe = (st == ST_RDATA) || (st == ST_XDATA);
        data_out = data_oe ? out_q : 8'h00;
    end

    // Main sequencer: command decode, handshakes and turnarounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_PWRUP;
            pw_cnt     <= '0;
            ext_q      <= 1'b0;
            addr_q     <= '0;
            wdat_q     <= '0;
            out_q      <= '0;
            we_q       <= 1'b0;
            tx_start_q <= 1'b0;
            tx_pid_q   <= '0;
            tx_valid_q <= 1'b0;
            tx_byte_q  <= '0;
        end else begin
            we_q       <= 1'b0;
            tx_start_q <= 1'b0;
            tx_valid_q <= 1'b0;
            case (st)
                ST_PWRUP: begin
                    if (pw_cnt == PW_LAST) st <= ST_FALL;
                    else                   pw_cnt <= pw_cnt + 1'b1;
                end
                ST_FALL: st <= ST_IDLE;
                ST_IDLE: begin
                    case (op)
                        OP_WRITE: begin
                            st     <= ST_WCMD;
                            ext_q  <= (link_data[5:0] == EXT_ADDR_CODE);
                            addr_q <= {2'b00, link_data[5:0]};
                        end
                        OP_READ: begin
                            st     <= ST_RCMD;
                            ext_q  <= (link_data[5:0] == EXT_ADDR_CODE);
                            addr_q <= {2'b00, link_data[5:0]};
                        end
                        OP_TX: begin
                            st       <= ST_TCMD;
                            tx_pid_q <= link_data[3:0];
                        end
                        default: begin
                            if (stat_changed) st <= ST_XTURN;
                        end
                    endcase
                end
                ST_WCMD: begin
                    if (stp)        st <= ST_IDLE;
                    else if (ext_q) st <= ST_WADDR;
                    else            st <= ST_WDATA;
                end
                ST_WADDR: begin
                    if (stp) st <= ST_IDLE;
                    else begin
                        addr_q <= link_data;
                        st     <= ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (stp) st <= ST_IDLE;
                    else begin
                        wdat_q <= link_data;
                        st     <= ST_WEND;
                    end
                end
                ST_WEND: begin
                    we_q <= stp;
                    st   <= ST_IDLE;
                end
                ST_RCMD: begin
                    if (stp)        st <= ST_IDLE;
                    else if (ext_q) st <= ST_RADDR;
                    else            st <= ST_RTURN;
                end
                ST_RADDR: begin
                    if (stp) st <= ST_IDLE;
                    else begin
                        addr_q <= link_data;
                        st     <= ST_RTURN;
                    end
                end
                ST_RTURN: begin
                    out_q <= reg_rdata;
                    st    <= ST_RDATA;
                end
                ST_RDATA: st <= ST_FALL;
                ST_XTURN: begin
                    out_q <= stat_byte;
                    st    <= ST_XDATA;
                end
                ST_XDATA: st <= ST_FALL;
                ST_TCMD: begin
                    if (stp) st <= ST_IDLE;
                    else begin
                        tx_start_q <= 1'b1;
                        st         <= ST_TDATA;
                    end
                end
                ST_TDATA: begin
                    if (stp) st <= ST_IDLE;
                    else begin
                        tx_valid_q <= 1'b1;
                        tx_byte_q  <= link_data;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign reg_we    = we_q;
    assign reg_addr  = addr_q;
    assign reg_wdata = wdat_q;
    assign tx_start  = tx_start_q;
    assign tx_pid    = tx_pid_q;
    assign tx_valid  = tx_valid_q;
    assign tx_byte   = tx_byte_q;

endmodule

// File: rtl/ulpi_phy_port.sv
// Top of the ULPI PHY-side controller: sequencer, status tracker and
// register bank. Assumes one clock domain and a synchronous reset.
module ulpi_phy_port
    import ulpi_phy_pkg::*;
#(
    parameter int PWRUP_CYCLES = 8,
    parameter int REG_COUNT    = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] link_data,
    output logic [7:0] phy_data,
    output logic       phy_data_oe,
    output logic       dir,
    output logic       nxt,
    input  logic       stp,
    input  logic [1:0] line_state,
    input  logic [1:0] vbus_state,
    input  logic [1:0] rx_event,
    output logic       tx_start,
    output logic [3:0] tx_pid,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);

    bus_status_t cur_stat;
    logic        stat_changed;
    logic        stat_take;
    logic [7:0]  stat_byte;
    logic        reg_we_w;
    logic [7:0]  reg_addr_w;
    logic [7:0]  reg_wdata_w;
    logic [7:0]  reg_rdata_w;

    assign cur_stat = '{ev: rx_event, vbus: vbus_state, line: line_state};

    ulpi_status_track i_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (cur_stat),
        .take      (stat_take),
        .changed   (stat_changed),
        .snap_byte (stat_byte)
    );

    ulpi_reg_bank #(
        .AW        (8),
        .DW        (8),
        .REG_COUNT (REG_COUNT)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we_w),
        .addr    (reg_addr_w),
        .wr_data (reg_wdata_w),
        .rd_data (reg_rdata_w)
    );

    ulpi_cmd_fsm #(
        .PWRUP_CYCLES (PWRUP_CYCLES)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_data    (link_data),
        .stp          (stp),
        .stat_changed (stat_changed),
        .stat_byte    (stat_byte),
        .reg_rdata    (reg_rdata_w),
        .stat_take    (stat_take),
        .dir          (dir),
        .nxt          (nxt),
        .data_oe      (phy_data_oe),
        .data_out     (phy_data),
        .reg_we       (reg_we_w),
        .reg_addr     (reg_addr_w),
        .reg_wdata    (reg_wdata_w),
        .tx_start     (tx_start),
        .tx_pid       (tx_pid),
        .tx_valid     (tx_valid),
        .tx_byte      (tx_byte)
    );

endmodule

// File: rtl/ulpi_phy_port_chk.sv
// Protocol checker bound to ulpi_phy_port; observes bus controls and the
// write strobe into the register bank.
module ulpi_phy_port_chk (
    input logic clk,
    input logic rst_n,
    input logic dir,
    input logic nxt,
    input logic phy_data_oe,
    input logic stp,
    input logic tx_valid,
    input logic reg_we
);

    // R6: the PHY drives only after a cycle with DIR already high.
    assert_drive_after_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phy_data_oe |-> $past(dir));

    // R6 / R8: the cycle in which DIR rises is never driven.
    assert_rise_undriven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir) |-> !phy_data_oe);

    // R7: the cycle after DIR falls neither accepts nor drives.
    assert_quiet_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir) |=> (!nxt && !phy_data_oe));

    // R8: NXT stays low while the PHY owns the bus.
    assert_no_nxt_with_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> !nxt);

    // R10: a payload byte is reported only after an accepting, non-STP cycle.
    assert_tx_byte_accepted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($past(nxt) && !$past(stp)));

    // R5: a register write follows a cycle with STP high and NXT low.
    assert_write_needs_stp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(stp) && !$past(nxt)));

endmodule

bind ulpi_phy_port ulpi_phy_port_chk i_ulpi_phy_port_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir         (dir),
    .nxt         (nxt),
    .phy_data_oe (phy_data_oe),
    .stp         (stp),
    .tx_valid    (tx_valid),
    .reg_we      (reg_we_w)
);

// File: tb/test_ulpi_phy_port.sv
module test_ulpi_phy_port;

    localparam int PW   = 8;
    localparam int REGS = 48;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] link_data;
    logic [7:0] phy_data;
    logic       phy_data_oe;
    logic       dir;
    logic       nxt;
    logic       stp;
    logic [1:0] line_state;
    logic [1:0] vbus_state;
    logic [1:0] rx_event;
    logic       tx_start;
    logic [3:0] tx_pid;
    logic       tx_valid;
    logic [7:0] tx_byte;

    int         total = 0;
    int         bad   = 0;
    logic [7:0] model [REGS];
    logic [5:0] last_rep;

    always #10 clk = ~clk;

    ulpi_phy_port #(.PWRUP_CYCLES(PW), .REG_COUNT(REGS)) i_ulpi_phy_port (
        .clk(clk), .rst_n(rst_n), .link_data(link_data), .phy_data(phy_data),
        .phy_data_oe(phy_data_oe), .dir(dir), .nxt(nxt), .stp(stp),
        .line_state(line_state), .vbus_state(vbus_state), .rx_event(rx_event),
        .tx_start(tx_start), .tx_pid(tx_pid), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_ext(input logic [7:0] a);
        return (a > 8'h3F) || (a[5:0] == 6'h2F);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        return (a < REGS) ? model[a] : 8'h00;
    endfunction

    // mode 0 commit, 1 STP before data (R11), 2 no STP after data (R5)
    task automatic wr(input logic [7:0] a, input logic [7:0] v, input int mode);
        bit ext = is_ext(a);
        link_data = ext ? 8'hAF : {2'b10, a[5:0]};
        @(negedge clk); chk(nxt === 1'b1, "R3 write command accepted", nxt, 1);
        @(negedge clk); chk(nxt === 1'b1, "R3 nxt held for next byte", nxt, 1);
        if (ext) begin
            link_data = a;
            @(negedge clk); chk(nxt === 1'b1, "R4 extended address taken", nxt, 1);
        end
        link_data = v;
        if (mode == 1) begin
            stp = 1'b1;
            @(negedge clk);
            stp = 1'b0; link_data = 8'h00;
            chk(nxt === 1'b0 && dir === 1'b0, "R11 abort returns idle", {dir, nxt}, 0);
            return;
        end
        @(negedge clk); chk(nxt === 1'b0, "R3 nxt low after data byte", nxt, 0);
        link_data = 8'h00;
        stp = (mode == 0);
        @(negedge clk);
        stp = 1'b0;
        if (mode == 0 && a < REGS) model[a] = v;
    endtask

    task automatic rd(input logic [7:0] a, input bit poke);
        bit ext = is_ext(a);
        logic [7:0] e = exp_read(a);
        link_data = ext ? 8'hEF : {2'b11, a[5:0]};
        @(negedge clk); chk(nxt === 1'b1, "R3 read command accepted", nxt, 1);
        if (ext) begin
            @(negedge clk); chk(nxt === 1'b1, "R4 extended read address", nxt, 1);
            link_data = a;
        end
        @(negedge clk);
        link_data = 8'h00;
        chk(dir === 1'b1 && phy_data_oe === 1'b0 && nxt === 1'b0, "R6 read turnaround",
            {dir, phy_data_oe, nxt}, 3'b100);
        @(negedge clk);
        chk(dir === 1'b1 && phy_data_oe === 1'b1 && nxt === 1'b0, "R6 read drive cycle",
            {dir, phy_data_oe, nxt}, 3'b110);
        chk(phy_data === e, "R4 R6 read data", phy_data, e);
        @(negedge clk);
        chk(dir === 1'b0 && phy_data_oe === 1'b0, "R6 dir released", {dir, phy_data_oe}, 0);
        if (poke) link_data = 8'h81;
        @(negedge clk);
        link_data = 8'h00;
        if (poke) begin
            @(negedge clk); chk(nxt === 1'b0 && dir === 1'b0, "R7 byte in fall cycle ignored", {dir, nxt}, 0);
            @(negedge clk); chk(nxt === 1'b0 && dir === 1'b0, "R7 still idle", {dir, nxt}, 0);
        end
    endtask

    task automatic expect_rx(input logic [5:0] s);
        @(negedge clk);
        chk(dir === 1'b1 && phy_data_oe === 1'b0 && nxt === 1'b0, "R8 status turnaround",
            {dir, phy_data_oe, nxt}, 3'b100);
        @(negedge clk);
        chk(dir === 1'b1 && phy_data_oe === 1'b1 && phy_data === {2'b00, s}, "R8 status byte",
            phy_data, {2'b00, s});
        @(negedge clk);
        chk(dir === 1'b0, "R8 status release", dir, 0);
        @(negedge clk);
        last_rep = s;
    endtask

    task automatic stat_set(input logic [5:0] s);
        {rx_event, vbus_state, line_state} = s;
        if (s != last_rep) expect_rx(s);
        else begin
            repeat (3) begin
                @(negedge clk); chk(dir === 1'b0, "R8 unchanged status sends nothing", dir, 0);
            end
        end
    endtask

    task automatic tx(input logic [3:0] pid, input int n);
        logic [7:0] b;
        link_data = {4'b0100, pid};
        @(negedge clk); chk(nxt === 1'b1, "R2 transmit command accepted", nxt, 1);
        @(negedge clk);
        chk(tx_start === 1'b1 && tx_pid === pid && nxt === 1'b1, "R10 start pulse and pid",
            {tx_start, tx_pid}, {1'b1, pid});
        for (int i = 0; i < n; i++) begin
            b = 8'($urandom_range(0, 255));
            link_data = b;
            @(negedge clk);
            chk(tx_valid === 1'b1 && tx_byte === b && tx_start === 1'b0, "R10 payload byte",
                tx_byte, b);
        end
        link_data = 8'h5A; stp = 1'b1;
        @(negedge clk);
        chk(tx_valid === 1'b0 && nxt === 1'b0, "R10 STP ends transfer", {tx_valid, nxt}, 0);
        stp = 1'b0; link_data = 8'h00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r;
        logic [7:0] a;
        logic [7:0] v;
        r = $urandom(32'd20240611);
        rst_n = 1'b0; link_data = 8'h00; stp = 1'b0;
        line_state = 2'b00; vbus_state = 2'b00; rx_event = 2'b00;
        last_rep = 6'h00;
        for (int i = 0; i < REGS; i++) model[i] = 8'h00;

        repeat (3) @(negedge clk);
        chk(dir === 1'b1 && nxt === 1'b0 && phy_data_oe === 1'b0, "R1 reset holds dir",
            {dir, nxt, phy_data_oe}, 3'b100);
        rst_n = 1'b1;
        for (int k = 1; k <= PW; k++) begin
            @(negedge clk);
            if (k < PW) chk(dir === 1'b1 && nxt === 1'b0 && phy_data_oe === 1'b0,
                            "R1 dir high after reset", {dir, nxt, phy_data_oe}, 3'b100);
            else        chk(dir === 1'b0, "R1 dir falls after power-up", dir, 0);
        end
        repeat (3) @(negedge clk);

        // Directed corner cases
        rd(8'h05, 1'b0);
        wr(8'h05, 8'hA5, 0); rd(8'h05, 1'b0);
        wr(8'h2F, 8'h3C, 0); rd(8'h2F, 1'b0);
        wr(8'h2E, 8'h77, 0); rd(8'h2E, 1'b1);
        wr(8'hC0, 8'h99, 0); rd(8'hC0, 1'b0);
        wr(8'h05, 8'h11, 1); rd(8'h05, 1'b0);
        wr(8'h05, 8'h22, 2); rd(8'h05, 1'b0);
        wr(8'h2F, 8'h44, 1); rd(8'h2F, 1'b0);

        link_data = 8'h15;
        repeat (3) begin
            @(negedge clk); chk(nxt === 1'b0 && dir === 1'b0, "R2 op 00 ignored", {dir, nxt}, 0);
        end
        link_data = 8'h00;

        stat_set(6'h01);
        stat_set(6'h01);
        stat_set(6'h3E);

        // R9: command and status change in the same idle cycle
        {rx_event, vbus_state, line_state} = 6'h12;
        wr(8'h07, 8'h5C, 0);
        expect_rx(6'h12);
        rd(8'h07, 1'b0);

        tx(4'h3, 3);
        tx(4'hD, 0);

        // Random rounds
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 6);
            a = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 63));
            v = 8'($urandom_range(0, 255));
            case (op)
                0, 1: wr(a, v, 0);
                2:    wr(a, v, $urandom_range(1, 2));
                3, 4: rd(a, 1'b0);
                5:    stat_set(($urandom_range(0, 1) == 0) ? last_rep : 6'($urandom_range(0, 63)));
                default: tx(4'($urandom_range(0, 15)), $urandom_range(0, 4));
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule